// File: doc/BRIEF.md
# PRBS-11 Bit Error Rate Monitor

This block watches a demodulated bit stream that is expected to carry a free-running PRBS-11 test pattern (period 2047 bits). It loads a local copy of the pattern generator from the received bits. Once enough received bits agree with the local copy, it declares synchronization. From then on, every received bit that disagrees with the regenerated sequence is an error.

Errors are summed over a measurement window made of a fixed number of accepted bits. At the end of each window the total is published as a 32-bit count. That count holds until the next window closes, and reading it does not clear it. A byte-wide read port exposes the count and the synchronization flag, so a supervisor can poll the link quality.

The bit input is a valid/ready stream. The block never applies back-pressure: ready is low only during reset and for the first cycle after it, and is high otherwise. A bit is taken on each rising clock edge where valid and ready are both high. Upstream may keep valid low for any number of cycles.

Top module: `prbs_ber_monitor`

## Requirements
- R1: The expected sequence follows b[n] = b[n-11] XOR b[n-9] (polynomial x^11 + x^9 + 1). A bit is accepted on each rising edge with s_valid and s_ready both high, and s_ready is high from the second cycle after reset release.
- R2: Acquisition loads 11 accepted bits into the local generator, then requires 64 consecutive matching bits. sync rises at the edge that accepts the 64th matching bit, which is the 75th accepted bit of an error-free acquisition.
- R3: A mismatch during the 64-bit confirmation discards that bit and restarts loading with the next accepted bit.
- R4: While synchronized, bits are grouped in blocks of 128, starting at the first bit after lock. The 17th error inside one block clears sync at the edge that accepts it, and loading restarts with the next bit. 16 errors in a block keep sync.
- R5: A bit is counted as an error only if sync is 1 when it is accepted and it differs from the regenerated bit. This includes the bit that drops sync.
- R6: Every accepted bit advances the window, whether or not the block is synchronized. The window has WINDOW_BITS bits (default 1,000,000). At the edge that accepts a window's last bit, err_count takes that window's total, and the next window starts from zero.
- R7: err_count keeps its value between window ends, and reading it has no effect on it.
- R8: rd_data is combinational from rd_addr. Addresses 0, 1, 2 and 3 return err_count bits 7:0, 15:8, 23:16 and 31:24. Address 4 returns sync in bit 0 and zeros elsewhere. Addresses 5 to 7 return zero.
- R9: Cycles where s_valid is low change neither the window position nor the lock state, whatever s_data is.
- R10: After reset, sync is 0, err_count is 0 and s_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Received bit is present |
| s_data | input | 1 | Received bit |
| s_ready | output | 1 | Bit can be taken (high outside reset) |
| sync | output | 1 | Pattern synchronization flag |
| err_count | output | 32 | Error total of the last completed window |
| rd_addr | input | 3 | Status register address |
| rd_data | output | 8 | Status register contents |

## Verification
sync and err_count both change at the same rising edge that accepts the deciding bit, with no further register stage. The bench therefore samples them one nanosecond after the edge that took that bit. The bit index where sync must rise or fall is worked out from the 11 + 64 acquisition rule and the 128-bit block grid. Window totals are checked right after each window's last bit and again one bit before the next window's end, to show the value holds. Reads through rd_addr are combinational, so each address is sampled a fraction of a nanosecond after it is applied, well before the next edge.

// File: rtl/ber_pkg.sv
package ber_pkg;
  localparam int PRBS_ORDER = 11;
  localparam int PRBS_TAP   = 9;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_CONF  = 2'd1,
    ST_TRACK = 2'd2
  } lock_state_e;
endpackage

// File: rtl/prbs11_predictor.sv
module prbs11_predictor #(
  parameter int ORDER = 11,
  parameter int TAP   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift,
  input  logic use_rx,
  input  logic rx_bit,
  output logic pred
);
  logic [ORDER-1:0] hist;

  assign pred = hist[ORDER-1] ^ hist[TAP-1];

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else if (shift) hist <= {hist[ORDER-2:0], (use_rx ? rx_bit : pred)};
  end

  // Generator state frozen on cycles without an accepted bit
  assert_hist_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(hist));
endmodule

// File: rtl/ber_lock_fsm.sv
module ber_lock_fsm
  import ber_pkg::*;
#(
  parameter int ORDER        = 11,
  parameter int LOCK_RUN     = 64,
  parameter int SPAN_BITS    = 128,
  parameter int SPAN_ERR_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic rx_bit,
  input  logic pred,
  output logic use_rx,
  output logic err_hit,
  output logic locked
);
  localparam int FILL_W = $clog2(ORDER + 1);
  localparam int RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int BLK_W  = $clog2(SPAN_BITS);
  localparam int BERR_W = $clog2(SPAN_ERR_MAX + 1);

  lock_state_e       st;
  logic [FILL_W-1:0] fill;
  logic [RUN_W-1:0]  run;
  logic [BLK_W-1:0]  blk;
  logic [BERR_W-1:0] blk_err;
  logic              miss;

  assign miss    = rx_bit ^ pred;
  assign use_rx  = (st == ST_LOAD);
  assign locked  = (st == ST_TRACK);
  assign err_hit = take && locked && miss;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_LOAD; fill <= '0; run <= '0; blk <= '0; blk_err <= '0;
    end else if (take) begin
      unique case (st)
        ST_LOAD: begin
          if (fill == FILL_W'(ORDER - 1)) begin
            st <= ST_CONF; run <= '0; fill <= '0;
          end else fill <= fill + 1'b1;
        end
        ST_CONF: begin
          if (miss) begin
            st <= ST_LOAD; fill <= '0;
          end else if (run == RUN_W'(LOCK_RUN - 1)) begin
            st <= ST_TRACK; blk <= '0; blk_err <= '0;
          end else run <= run + 1'b1;
        end
        ST_TRACK: begin
          if (miss && blk_err == BERR_W'(SPAN_ERR_MAX)) begin
            st <= ST_LOAD; fill <= '0;
          end else if (blk == BLK_W'(SPAN_BITS - 1)) begin
            blk <= '0; blk_err <= '0;
          end else begin
            blk <= blk + 1'b1;
            blk_err <= blk_err + BERR_W'(miss);
          end
        end
        default: st <= ST_LOAD;
      endcase
    end
  end

  assert_lock_from_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(st) == ST_CONF);
  assert_drop_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(take) && $past(miss));
  assert_confirm_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CONF && take && miss) |=> st == ST_LOAD && fill == '0);
  assert_idle_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(st));
endmodule

// File: rtl/ber_window.sv
module ber_window #(
  parameter int WINDOW_BITS = 1000000,
  parameter int COUNT_W     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               err_hit,
  output logic [COUNT_W-1:0] pub
);
  localparam int POS_W = $clog2(WINDOW_BITS);

  logic [POS_W-1:0]   pos;
  logic [COUNT_W-1:0] acc;
  logic               last;
  logic               close;

  assign last  = (pos == POS_W'(WINDOW_BITS - 1));
  assign close = take && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; acc <= '0; pub <= '0;
    end else if (take) begin
      if (last) begin
        pub <= acc + COUNT_W'(err_hit);
        acc <= '0;
        pos <= '0;
      end else begin
        acc <= acc + COUNT_W'(err_hit);
        pos <= pos + 1'b1;
      end
    end
  end

  assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pos < POS_W'(WINDOW_BITS));
  assert_pub_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pub) |-> $past(close));
  assert_idle_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pos) && $stable(acc));
endmodule

// File: rtl/prbs_ber_monitor.sv
module prbs_ber_monitor
  import ber_pkg::*;
#(
  parameter int WINDOW_BITS  = 1000000,
  parameter int LOCK_RUN     = 64,
  parameter int SPAN_BITS    = 128,
  parameter int SPAN_ERR_MAX = 16,
  parameter int COUNT_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  input  logic               s_data,
  output logic               s_ready,
  output logic               sync,
  output logic [COUNT_W-1:0] err_count,
  input  logic [2:0]         rd_addr,
  output logic [7:0]         rd_data
);
  localparam int NBYTES = COUNT_W / 8;

  logic take, pred, use_rx, err_hit;
  logic [7:0] byte_view [NBYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) s_ready <= 1'b0;
    else        s_ready <= 1'b1;
  end

  assign take = s_valid && s_ready;

  prbs11_predictor #(.ORDER(PRBS_ORDER), .TAP(PRBS_TAP)) u_pred (
    .clk(clk), .rst_n(rst_n), .shift(take), .use_rx(use_rx),
    .rx_bit(s_data), .pred(pred));

  ber_lock_fsm #(.ORDER(PRBS_ORDER), .LOCK_RUN(LOCK_RUN),
                 .SPAN_BITS(SPAN_BITS), .SPAN_ERR_MAX(SPAN_ERR_MAX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take), .rx_bit(s_data), .pred(pred),
    .use_rx(use_rx), .err_hit(err_hit), .locked(sync));

  ber_window #(.WINDOW_BITS(WINDOW_BITS), .COUNT_W(COUNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .take(take), .err_hit(err_hit), .pub(err_count));

  for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
    assign byte_view[g] = err_count[8*g +: 8];
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_addr) < NBYTES) rd_data = byte_view[rd_addr];
    else if (int'(rd_addr) == NBYTES) rd_data = {7'b0, sync};
  end

  assert_err_needs_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_hit |-> sync);
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);
endmodule

// File: tb/test_prbs_ber_monitor.sv
`timescale 1ns/1ps
module test_prbs_ber_monitor;
  localparam int W = 2000;
  localparam int NBITS = 10000;

  logic clk = 0, rst_n = 0, s_valid = 0, s_data = 0;
  logic s_ready, sync;
  logic [31:0] err_count;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prbs_ber_monitor #(.WINDOW_BITS(W)) i_prbs_ber_monitor (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .sync(sync), .err_count(err_count),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_all(input string req, input logic [31:0] exp);
    logic [31:0] got;
    for (int i = 0; i < 4; i++) begin
      rd_addr = 3'(i); #0.2;
      got[8*i +: 8] = rd_data;
    end
    chk(req, got, exp);
  endtask

  function automatic bit is_err(input int n);
    return n == 50 || n == 300 || n == 301 || n == 1000 || n == 2000 ||
           n == 2001 || n == 3999 || (n >= 2700 && n <= 2715) ||
           (n >= 4480 && n <= 4496) || n == 5000 || n == 5500 ||
           (n > 6000 && n <= 8000 && ((n - 4572) % 128) < 16);
  endfunction

  function automatic bit model_locked(input int n);
    return (n >= 126 && n <= 4496) || n >= 4572;
  endfunction

  initial begin
    logic [10:0] th = 11'h5A5;
    int exp_acc = 0;
    logic [31:0] exp_pub = 0;
    logic b;
    repeat (4) @(posedge clk);
    #1;
    // R10: reset values
    chk("R10 sync", sync, 0);
    chk("R10 count", err_count, 0);
    chk("R10 ready", s_ready, 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 ready", s_ready, 1);
    read_all("R10 bytes", 0);
    for (int n = 1; n <= NBITS; n++) begin
      if (n % 7 == 0) begin
        @(negedge clk) begin s_valid = 0; s_data = ~s_data; end
        @(posedge clk);
      end
      b = th[10] ^ th[8];
      th = {th[9:0], b};
      if (is_err(n) && model_locked(n)) exp_acc++;
      @(negedge clk) begin s_valid = 1; s_data = b ^ is_err(n); end
      @(posedge clk); #1;
      s_valid = 0;
      if (n == 49)   chk("R2 sync before lock", sync, 0);
      if (n == 124)  chk("R3 sync delayed by restart", sync, 0);
      if (n == 125)  chk("R2 R1 sync rises", sync, 1);
      if (n == 4495) chk("R4 sync held 16 errs", sync, 1);
      if (n == 4496) chk("R4 sync drop 17th", sync, 0);
      if (n == 4570) chk("R4 reacquire pending", sync, 0);
      if (n == 4571) begin
        chk("R4 reacquired", sync, 1);
        rd_addr = 3'd4; #0.2;
        chk("R8 sync reg", rd_data, 8'h01);
        rd_addr = 3'd6; #0.2;
        chk("R8 unused reg", rd_data, 8'h00);
      end
      if (n % W == W - 1) chk("R7 hold before close", err_count, exp_pub);
      if (n % W == 0) begin
        exp_pub = exp_acc;
        exp_acc = 0;
        chk("R6 R5 window total", err_count, exp_pub);
        read_all("R8 bytes", exp_pub);
        read_all("R7 reread", exp_pub);
      end
    end
    // R9: idle cycles with toggling data leave everything unchanged
    repeat (20) begin
      @(negedge clk) s_data = ~s_data;
      @(posedge clk);
    end
    #1;
    chk("R9 idle count", err_count, exp_pub);
    chk("R9 idle sync", sync, 1);
    read_all("R7 final read", exp_pub);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule